// File: doc/BRIEF.md
# Reference-Counted Chained Buffer Release Engine

This block takes back packet buffers once a downstream stage has finished with them. Each buffer has a descriptor in a small local register array. The descriptor holds three things: an 8-bit reference count, a 32-bit pointer to the next buffer in the chain, and a 4-bit pool tag.

The surrounding stages use two update ports:

- The receive stage loads a descriptor through a write port.
- The copy stage adds references through an increment port.

When a buffer handle is released, the engine decrements that buffer's count. The buffer is handed to the free list only if the count reaches zero. In that case the engine follows the next pointer and releases the chained buffer the same way. A null pointer ends the walk.

The same block also moves handles from an input ring to a point-to-point output. This forwarding path has lower priority than release work. It is granted in two situations:

- the release side has nothing to do, or
- the release side is stalled by a full free list.

Because of the second case, a back-pressured free list can never stop the forwarding path that its own producer may be waiting on.

Top module: `chain_buf_release`

## Requirements
- R1: After reset every descriptor reads count 0, next 0 and pool 0; `rel_ready` is 1, `fl_valid` is 0 and `ref_err` is 0.
- R2: A write-port cycle loads the count and next pointer of the addressed descriptor and clears its pool tag to 0. An increment cycle adds one to the count, saturating at 255.
- R3: A released buffer whose count is still nonzero after the decrement is not put on the free list, and its next pointer is not followed.
- R4: A buffer whose count reaches zero appears on the free list with `fl_pool` equal to `POOL_ID` (default 1). Its descriptor pool tag then reads `POOL_ID`.
- R5: After a buffer is freed, the engine releases the buffer its next pointer names, repeating down the chain. A next pointer of all zeros ends the walk, so handle 0 never appears on the free list.
- R6: Releasing a buffer whose count is already 0 sets `ref_err`, frees nothing and ends the walk. `ref_err` stays set until reset.
- R7: A release of handle 0 is accepted and has no effect on any descriptor or on the free list.
- R8: While `fl_valid` is high and `fl_ready` is low, `fl_valid` and `fl_handle` hold.
- R9: Forwarding (`fw_in_ready` = `fw_out_ready`, `fw_out_valid` = `fw_in_valid`, handle passed through) is enabled in two cases only: idle with no release pending, or a free-list entry waiting on `fl_ready` low. It is blocked in every other cycle.
- R10: An increment that lands on the descriptor in the same cycle as its decrement leaves the count unchanged, and the buffer is not freed. A write-port cycle overrides both.
- R11: `rel_ready` is high only while no release is in progress. A release takes one cycle per descriptor, plus the free-list handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dw_en | input | 1 | Descriptor load strobe |
| dw_addr | input | 4 | Descriptor index to load |
| dw_ref | input | 8 | Reference count to load |
| dw_next | input | 32 | Next-buffer pointer to load |
| inc_en | input | 1 | Reference increment strobe |
| inc_addr | input | 4 | Descriptor index to increment |
| rel_valid | input | 1 | Release request valid |
| rel_ready | output | 1 | Release request accepted |
| rel_handle | input | 32 | Handle to release |
| fl_valid | output | 1 | Free-list entry valid |
| fl_ready | input | 1 | Free list can take an entry |
| fl_handle | output | 32 | Freed buffer handle |
| fl_pool | output | 4 | Pool tag of freed buffer |
| fw_in_valid | input | 1 | Input ring entry valid |
| fw_in_ready | output | 1 | Input ring entry taken |
| fw_in_handle | input | 32 | Input ring handle |
| fw_out_valid | output | 1 | Forward output valid |
| fw_out_ready | input | 1 | Forward output can accept |
| fw_out_handle | output | 32 | Forwarded handle |
| rd_addr | input | 4 | Descriptor read index |
| rd_ref | output | 8 | Count of read descriptor |
| rd_next | output | 32 | Next pointer of read descriptor |
| rd_pool | output | 4 | Pool tag of read descriptor |
| ref_err | output | 1 | Sticky decrement-of-zero flag |

## Verification
Most internal faults in this block show up as a wrong free-list sequence within a few cycles of the release. Examples:

- A count decremented twice, or not at all, frees a buffer early or never frees it.
- A chain followed past a live buffer frees the shared payload too soon.
- A mis-set walk state emits a null or repeated handle.

The same faults leave a descriptor count that differs from the expected value when it is read back after the release finishes. An arbitration fault shows up in the same cycle: `fw_in_ready` is wrong while a release is pending, walking, or stalled on the free list.

// File: rtl/chain_buf_release.sv
module chain_buf_release #(
  parameter int PW      = 32,
  parameter int NBUF    = 16,
  parameter int POOL_ID = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dw_en,
  input  logic [$clog2(NBUF)-1:0]   dw_addr,
  input  logic [7:0]                dw_ref,
  input  logic [PW-1:0]             dw_next,
  input  logic                      inc_en,
  input  logic [$clog2(NBUF)-1:0]   inc_addr,
  input  logic                      rel_valid,
  output logic                      rel_ready,
  input  logic [PW-1:0]             rel_handle,
  output logic                      fl_valid,
  input  logic                      fl_ready,
  output logic [PW-1:0]             fl_handle,
  output logic [3:0]                fl_pool,
  input  logic                      fw_in_valid,
  output logic                      fw_in_ready,
  input  logic [PW-1:0]             fw_in_handle,
  output logic                      fw_out_valid,
  input  logic                      fw_out_ready,
  output logic [PW-1:0]             fw_out_handle,
  input  logic [$clog2(NBUF)-1:0]   rd_addr,
  output logic [7:0]                rd_ref,
  output logic [PW-1:0]             rd_next,
  output logic [3:0]                rd_pool,
  output logic                      ref_err
);
  localparam int AW = $clog2(NBUF);
  localparam logic [3:0] POOL = 4'(POOL_ID);

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_PUSH} st_t;
  st_t st;
  logic [PW-1:0] cur;
  logic [7:0]    ref_q  [NBUF];
  logic [PW-1:0] nxt_q  [NBUF];
  logic [3:0]    pool_q [NBUF];

  wire [AW-1:0] cur_idx  = cur[AW-1:0];
  wire [7:0]    cur_ref  = ref_q[cur_idx];
  wire [PW-1:0] cur_nxt  = nxt_q[cur_idx];
  wire          inc_hit  = inc_en && inc_addr == cur_idx;
  wire          dw_hit   = dw_en && dw_addr == cur_idx;
  wire          dec_go   = st == S_WALK && cur_ref != 8'd0;
  wire          free_now = dec_go && cur_ref == 8'd1 && !inc_hit && !dw_hit;

  genvar gi;
  generate
    for (gi = 0; gi < NBUF; gi++) begin : g_desc
      wire ld_i  = dw_en && dw_addr == AW'(gi);
      wire inc_i = inc_en && inc_addr == AW'(gi);
      wire dec_i = dec_go && cur_idx == AW'(gi);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ref_q[gi]  <= '0;
          nxt_q[gi]  <= '0;
          pool_q[gi] <= '0;
        end else if (ld_i) begin
          ref_q[gi]  <= dw_ref;
          nxt_q[gi]  <= dw_next;
          pool_q[gi] <= '0;
        end else begin
          if (inc_i && !dec_i && ref_q[gi] != 8'hFF) ref_q[gi] <= ref_q[gi] + 8'd1;
          if (dec_i && !inc_i) ref_q[gi] <= ref_q[gi] - 8'd1;
          if (dec_i && free_now) pool_q[gi] <= POOL;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cur     <= '0;
      ref_err <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (rel_valid && rel_handle != '0) begin
          cur <= rel_handle;
          st  <= S_WALK;
        end
        S_WALK: begin
          if (cur_ref == 8'd0) begin
            ref_err <= 1'b1;
            st      <= S_IDLE;
          end else if (free_now) st <= S_PUSH;
          else st <= S_IDLE;
        end
        S_PUSH: if (fl_ready) begin
          if (cur_nxt != '0) begin
            cur <= cur_nxt;
            st  <= S_WALK;
          end else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rel_ready = st == S_IDLE;
  assign fl_valid  = st == S_PUSH;
  assign fl_handle = cur;
  assign fl_pool   = pool_q[cur_idx];

  wire fw_grant = (st == S_IDLE && !rel_valid) || (st == S_PUSH && !fl_ready);
  assign fw_in_ready   = fw_grant && fw_out_ready;
  assign fw_out_valid  = fw_grant && fw_in_valid;
  assign fw_out_handle = fw_in_handle;

  assign rd_ref  = ref_q[rd_addr];
  assign rd_next = nxt_q[rd_addr];
  assign rd_pool = pool_q[rd_addr];

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid && !fl_ready |=> fl_valid && $stable(fl_handle));
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_err |=> ref_err);
  assert_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid && rel_ready |-> !fw_in_ready);
  assert_unblock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid && !fl_ready && fw_out_ready |-> fw_in_ready);
  assert_nonnull_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid |-> fl_handle != '0);
  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rel_ready |-> !fl_valid);
endmodule

// File: tb/chain_buf_release_tb.sv
`timescale 1ns/1ps
module chain_buf_release_tb;
  localparam int PW = 32, NBUF = 16, AW = 4, POOL_ID = 1;
  logic clk = 0, rst_n = 0;
  logic dw_en = 0, inc_en = 0, rel_valid = 0, fl_ready = 0;
  logic fw_in_valid = 0, fw_out_ready = 0;
  logic [AW-1:0] dw_addr = 0, inc_addr = 0, rd_addr = 0;
  logic [7:0] dw_ref = 0;
  logic [PW-1:0] dw_next = 0, rel_handle = 0, fw_in_handle = 0;
  logic rel_ready, fl_valid, fw_in_ready, fw_out_valid, ref_err;
  logic [PW-1:0] fl_handle, fw_out_handle, rd_next;
  logic [3:0] fl_pool, rd_pool;
  logic [7:0] rd_ref;

  chain_buf_release #(.PW(PW), .NBUF(NBUF), .POOL_ID(POOL_ID)) u_dut (
    .clk(clk), .rst_n(rst_n), .dw_en(dw_en), .dw_addr(dw_addr), .dw_ref(dw_ref),
    .dw_next(dw_next), .inc_en(inc_en), .inc_addr(inc_addr), .rel_valid(rel_valid),
    .rel_ready(rel_ready), .rel_handle(rel_handle), .fl_valid(fl_valid),
    .fl_ready(fl_ready), .fl_handle(fl_handle), .fl_pool(fl_pool),
    .fw_in_valid(fw_in_valid), .fw_in_ready(fw_in_ready), .fw_in_handle(fw_in_handle),
    .fw_out_valid(fw_out_valid), .fw_out_ready(fw_out_ready),
    .fw_out_handle(fw_out_handle), .rd_addr(rd_addr), .rd_ref(rd_ref),
    .rd_next(rd_next), .rd_pool(rd_pool), .ref_err(ref_err));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, mode = 1;
  bit done = 0;
  logic [7:0]    m_ref  [NBUF];
  logic [PW-1:0] m_next [NBUF];
  logic [3:0]    m_pool [NBUF];
  bit m_err = 0;
  logic [PW-1:0] expq [$];
  logic [PW-1:0] gotq [$];

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_rel(logic [PW-1:0] h);
    while (h != 0) begin
      int i = int'(h[AW-1:0]);
      if (m_ref[i] == 0) begin m_err = 1; break; end
      m_ref[i] = m_ref[i] - 1;
      if (m_ref[i] != 0) break;
      m_pool[i] = 4'(POOL_ID);
      expq.push_back(h);
      h = m_next[i];
    end
  endfunction

  initial forever begin
    @(negedge clk);
    fl_ready = (mode == 0) ? 1'($urandom % 2) : (mode == 1);
    #1;
    if (fl_valid && fl_ready) begin
      gotq.push_back(fl_handle);
      chk(fl_pool == 4'(POOL_ID), "R4 pool tag", fl_pool, POOL_ID);
    end
  end

  task automatic wr(int a, int r, int n);
    @(negedge clk);
    dw_en = 1; dw_addr = AW'(a); dw_ref = 8'(r); dw_next = PW'(n);
    @(negedge clk);
    dw_en = 0;
    m_ref[a] = 8'(r); m_next[a] = PW'(n); m_pool[a] = 0;
  endtask

  task automatic inc1(int a);
    @(negedge clk);
    inc_en = 1; inc_addr = AW'(a);
    @(negedge clk);
    inc_en = 0;
    if (m_ref[a] != 8'hFF) m_ref[a] = m_ref[a] + 1;
  endtask

  task automatic wait_idle();
    while (!rel_ready) @(negedge clk);
  endtask

  task automatic rel(int h);
    @(negedge clk);
    wait_idle();
    rel_valid = 1; rel_handle = PW'(h);
    @(negedge clk);
    rel_valid = 0;
    wait_idle();
    model_rel(PW'(h));
  endtask

  task automatic cmp_q(string req);
    chk(gotq.size() == expq.size(), req, gotq.size(), expq.size());
    for (int k = 0; k < expq.size() && k < gotq.size(); k++)
      chk(gotq[k] == expq[k], req, gotq[k], expq[k]);
    gotq.delete(); expq.delete();
  endtask

  task automatic cmp_desc(string req);
    for (int i = 0; i < NBUF; i++) begin
      rd_addr = AW'(i); #0.1;
      chk(rd_ref == m_ref[i], req, rd_ref, m_ref[i]);
      chk(rd_next == m_next[i], req, rd_next, m_next[i]);
      chk(rd_pool == m_pool[i], req, rd_pool, m_pool[i]);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NBUF; i++) begin m_ref[i] = 0; m_next[i] = 0; m_pool[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk(rel_ready == 1, "R1 rel_ready", rel_ready, 1);
    chk(fl_valid == 0, "R1 fl_valid", fl_valid, 0);
    chk(ref_err == 0, "R1 ref_err", ref_err, 0);
    cmp_desc("R1 descriptor reset");

    // R2 load and saturating increment
    wr(7, 254, 3);
    inc1(7); inc1(7);
    @(negedge clk); cmp_desc("R2 load/increment");

    // R7 null release ignored
    rel(0);
    cmp_q("R7 null release"); cmp_desc("R7 null release");

    // R3 R5 shared payload chain
    wr(2, 1, 4); wr(6, 1, 4); wr(4, 2, 0);
    rel(2); cmp_q("R3 R5 header freed, payload kept");
    @(negedge clk); cmp_desc("R3 payload count");
    rel(6); cmp_q("R5 header and payload freed");
    @(negedge clk); cmp_desc("R4 R5 descriptors after chain");

    // R10 increment coincident with decrement
    wr(9, 2, 0);
    @(negedge clk); wait_idle();
    rel_valid = 1; rel_handle = 9;
    @(negedge clk);
    rel_valid = 0; inc_en = 1; inc_addr = 9;
    @(negedge clk);
    inc_en = 0;
    wait_idle();
    cmp_q("R10 no free on coincident inc");
    rd_addr = 9; #0.1;
    chk(rd_ref == 2, "R10 count unchanged", rd_ref, 2);

    // R9 arbitration
    @(negedge clk);
    fw_in_valid = 1; fw_out_ready = 1; fw_in_handle = 32'hABCD0001; #1;
    chk(fw_in_ready == 1, "R9 idle forward", fw_in_ready, 1);
    chk(fw_out_valid == 1 && fw_out_handle == 32'hABCD0001, "R9 idle pass", fw_out_handle, 32'hABCD0001);
    rel_valid = 1; rel_handle = 0; #1;
    chk(fw_in_ready == 0, "R9 pending release blocks", fw_in_ready, 0);
    @(negedge clk); rel_valid = 0;
    wr(3, 1, 0);
    mode = 2;
    @(negedge clk);
    rel_valid = 1; rel_handle = 3;
    @(negedge clk);
    rel_valid = 0; #1;
    chk(fw_in_ready == 0, "R9 walk blocks forward", fw_in_ready, 0);
    chk(rel_ready == 0, "R11 busy during walk", rel_ready, 0);
    @(negedge clk); #1;
    chk(fl_valid == 1 && fl_handle == 3, "R8 entry offered", fl_handle, 3);
    chk(fw_in_ready == 1, "R9 blocked free lets forward run", fw_in_ready, 1);
    repeat (3) @(negedge clk); #1;
    chk(fl_valid == 1 && fl_handle == 3, "R8 entry held", fl_handle, 3);
    fw_in_valid = 0; fw_out_ready = 0;
    mode = 1;
    wait_idle();
    model_rel(3);
    cmp_q("R4 blocked entry drained");

    // random chains with random free-list back-pressure
    mode = 0;
    for (int it = 0; it < 40; it++) begin
      int len = 1 + int'($urandom % 3);
      int st  = 1 + int'($urandom % 15);
      int ad[3];
      for (int k = 0; k < 3; k++) ad[k] = 1 + ((st - 1 + k) % 15);
      for (int k = len - 1; k >= 0; k--)
        wr(ad[k], 1 + int'($urandom % 3), (k == len - 1) ? 0 : ad[k + 1]);
      if ($urandom % 4 == 0) inc1(ad[0]);
      for (int r = 0; r < 5 && m_ref[ad[0]] != 0; r++) rel(ad[0]);
      cmp_q("R3 R4 R5 random chain");
    end
    @(negedge clk); cmp_desc("R2 R3 random descriptors");
    chk(ref_err == 0, "R6 no error on valid use", ref_err, 0);

    // R6 decrement of zero
    mode = 1;
    wr(5, 0, 6); wr(6, 1, 0);
    rel(5);
    cmp_q("R6 nothing freed");
    #1; chk(ref_err == 1, "R6 error set", ref_err, 1);
    @(negedge clk); cmp_desc("R6 walk stopped");
    rel(6); cmp_q("R6 later release");
    #1; chk(ref_err == 1, "R6 error sticky", ref_err, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule